// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings an asynchronous DRAM out of power-up and then keeps its contents alive. It uses refresh cycles in which CAS falls before RAS, so the row comes from the memory's internal counter. No refresh address is driven, and the data pins are left alone. After reset it keeps both strobes inactive for a long settling pause. It then issues a fixed number of warm-up refresh cycles on its own, without asking for the bus. Only after that does it raise `ready`, which tells the access controller it may begin normal traffic.

In normal operation an interval timer adds one owed refresh every `INTERVAL_CYC` clocks. The default pace puts all 4096 rows inside the retention period. While anything is owed, the block holds `rfsh_req` to the access controller. A pending refresh outranks new accesses. If the controller still has a row open, `close_req` asks it to precharge. Once `rfsh_gnt` is high and `row_open` is low, the block takes the strobes. It then works off every owed refresh back to back before giving the bus back.

Refreshes that could not run because the bus was busy are counted, up to `MAX_DEBT`. All strobe timings are clock counts set by parameters.

Top module: `dram_rfsh_seq`

## Requirements
- R1: After `rst_n` is released, `ras_n` and `cas_n` stay 1 and `ready`, `rfsh_req` and `bus_own` stay 0 through the pause. With the default two-stage reset synchronizer, the first CAS fall (1→0 on `cas_n`) comes exactly `PAUSE_CYC + RP_CYC + 1` cycles after release.
- R2: After the pause, exactly `INIT_CYCLES` refresh cycles are issued without any grant. `ready` rises exactly `RP_CYC` cycles after `ras_n` returns to 1 at the end of the last of them.
- R3: Every refresh cycle has the same shape:
  - `cas_n` is 0 for exactly `CSR_CYC` cycles before `ras_n` falls.
  - Both strobes are then 0 for exactly `CHR_CYC` cycles.
  - `ras_n` is 0 for exactly `RAS_CYC` cycles in total.
  - Every CAS fall is preceded by at least `RP_CYC` cycles with both strobes at 1.
- R4: Once `ready` is 1, one refresh becomes owed every `INTERVAL_CYC` cycles. `rfsh_req` first rises exactly `INTERVAL_CYC` cycles after `ready` rises, and it is 1 whenever a refresh is owed.
- R5: A refresh cycle starts only when `rfsh_gnt`=1 and `row_open`=0. While a refresh is owed, the block does not own the bus and `row_open`=1, `close_req` is 1. With nothing owed, `close_req` is 0 and granting the bus produces no cycle.
- R6: The count of owed refreshes saturates at `MAX_DEBT`. Within one grant, all owed refreshes are issued back to back, so the number of RAS falls equals min(intervals elapsed, `MAX_DEBT`).
- R7: `bus_own` is 1 whenever either strobe is 0. Once `ready` has risen, it never falls.
- R8: `rfsh_req` falls exactly `RP_CYC` cycles after the final RAS rise of a burst, and `bus_own` falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| rfsh_gnt | input | 1 | Access controller hands the strobes to the sequencer |
| row_open | input | 1 | Access controller currently holds a row active |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | 1 | Column strobe(s) to the DRAM, active low |
| bus_own | output | 1 | Sequencer is driving the strobes |
| rfsh_req | output | 1 | Refresh owed or in progress |
| close_req | output | 1 | Asks the access controller to precharge its open row |
| ready | output | 1 | Initialisation finished, normal accesses allowed |

## Verification
Each result has a fixed cycle in which it is due:
- the first CAS fall, `PAUSE_CYC + RP_CYC + 1` cycles after reset release;
- `ready`, `RP_CYC` cycles after the last warm-up RAS rise;
- the first request, `INTERVAL_CYC` cycles after `ready`;
- each RAS fall, `CSR_CYC` cycles after its CAS fall;
- the request drop, `RP_CYC` cycles after the final RAS rise of a burst.

The bench samples every output on the falling clock edge and keeps run-length counters for each strobe level. It compares each measured length or distance with the exact figure. Grants are given 10 cycles after an interval boundary, so the owed count at that moment is known from the requirements alone.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_PRE,
    ST_CSR,
    ST_ACT,
    ST_HOLD
  } rfsh_st_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_pace.sv
// Interval timer: one tick every INTERVAL_CYC cycles while run is high.
module rfsh_pace #(
  parameter int unsigned INTERVAL_CYC = 3900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned PW = $clog2(INTERVAL_CYC + 1);
  localparam logic [PW-1:0] RELOAD = PW'(INTERVAL_CYC - 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick   = run && (cnt_q == '0);
  assign cnt_en = 1'b1;

  always_comb begin
    if (!run || tick) cnt_d = RELOAD;
    else              cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RELOAD;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_tick_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (INTERVAL_CYC > 1)) |=> !tick);

endmodule

// File: rtl/rfsh_backlog.sv
// Saturating count of refreshes owed but not yet issued.
module rfsh_backlog #(
  parameter int unsigned MAX_DEBT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic owed
);
  localparam int unsigned DW = $clog2(MAX_DEBT + 1);
  localparam logic [DW-1:0] FULL = DW'(MAX_DEBT);

  logic [DW-1:0] debt_q, debt_d;

  assign owed = (debt_q != '0);

  always_comb begin
    debt_d = debt_q;
    if (inc && !dec) begin
      if (debt_q != FULL) debt_d = debt_q + 1'b1;
    end else if (dec && !inc) begin
      debt_d = debt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) debt_q <= '0;
    else        debt_q <= debt_d;
  end

  assert_debt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    debt_q <= FULL);

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (debt_q != '0));

endmodule

// File: rtl/rfsh_strobe_fsm.sv
// Strobe sequencer: pause, warm-up cycles, then granted refresh bursts.
module rfsh_strobe_fsm
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned PAUSE_CYC   = 50000,
  parameter int unsigned INIT_CYCLES = 8,
  parameter int unsigned RP_CYC      = 8,
  parameter int unsigned CSR_CYC     = 1,
  parameter int unsigned CHR_CYC     = 3,
  parameter int unsigned RAS_CYC     = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic owed,
  input  logic gnt,
  input  logic row_open,
  output logic ras_n,
  output logic cas_n,
  output logic bus_own,
  output logic ready,
  output logic dec
);
  localparam int unsigned LONGEST = umax(umax(PAUSE_CYC, RAS_CYC), umax(RP_CYC, CSR_CYC));
  localparam int unsigned CW = $clog2(LONGEST + 1);
  localparam int unsigned IW = $clog2(INIT_CYCLES + 1);
  localparam logic [CW-1:0] PAUSE_LD = CW'(PAUSE_CYC - 1);
  localparam logic [CW-1:0] RP_LD    = CW'(RP_CYC - 1);
  localparam logic [CW-1:0] CSR_LD   = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] CHR_LD   = CW'(CHR_CYC - 1);
  localparam logic [CW-1:0] HOLD_LD  = CW'(RAS_CYC - CHR_CYC - 1);

  rfsh_st_e      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] init_q, init_d;
  logic          ready_q, ready_d;
  logic          ras_n_q, cas_n_q, own_q;
  logic          last, may_go;

  assign last   = (cnt_q == '0);
  assign may_go = owed && gnt && !row_open;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    init_d  = init_q;
    ready_d = ready_q;
    dec     = 1'b0;
    if (st_q != ST_IDLE && !last) cnt_d = cnt_q - 1'b1;
    case (st_q)
      ST_PAUSE: if (last) begin st_d = ST_PRE; cnt_d = RP_LD; end
      ST_IDLE:  if (ready_q && may_go) begin st_d = ST_PRE; cnt_d = RP_LD; end
      ST_PRE: if (last) begin
        if (!ready_q) begin
          if (init_q != '0) begin st_d = ST_CSR; cnt_d = CSR_LD; end
          else begin st_d = ST_IDLE; ready_d = 1'b1; end
        end else if (may_go) begin
          st_d = ST_CSR; cnt_d = CSR_LD;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_CSR: if (last) begin
        st_d  = ST_ACT;
        cnt_d = CHR_LD;
        if (ready_q) dec = 1'b1;
        else         init_d = init_q - 1'b1;
      end
      ST_ACT:  if (last) begin st_d = ST_HOLD; cnt_d = HOLD_LD; end
      ST_HOLD: if (last) begin st_d = ST_PRE;  cnt_d = RP_LD;   end
      default: begin st_d = ST_IDLE; end
    endcase
  end

  // registers; strobes are registered from the next state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_PAUSE;
      cnt_q   <= PAUSE_LD;
      init_q  <= IW'(INIT_CYCLES);
      ready_q <= 1'b0;
      ras_n_q <= 1'b1;
      cas_n_q <= 1'b1;
      own_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      init_q  <= init_d;
      ready_q <= ready_d;
      ras_n_q <= !(st_d == ST_ACT || st_d == ST_HOLD);
      cas_n_q <= !(st_d == ST_CSR || st_d == ST_ACT);
      own_q   <= (st_d == ST_PRE) || (st_d == ST_CSR) || (st_d == ST_ACT) || (st_d == ST_HOLD);
    end
  end

  assign ras_n   = ras_n_q;
  assign cas_n   = cas_n_q;
  assign bus_own = own_q;
  assign ready   = ready_q;

  assert_pause_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAUSE) |-> (ras_n_q && cas_n_q && !ready_q));

  assert_cas_leads_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_q) |-> (!cas_n_q && $past(!cas_n_q)));

  assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> ready_q);

endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq #(
  parameter int unsigned PAUSE_CYC    = 50000,
  parameter int unsigned INIT_CYCLES  = 8,
  parameter int unsigned INTERVAL_CYC = 3900,
  parameter int unsigned MAX_DEBT     = 8,
  parameter int unsigned RP_CYC       = 8,
  parameter int unsigned CSR_CYC      = 1,
  parameter int unsigned CHR_CYC      = 3,
  parameter int unsigned RAS_CYC      = 13,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rfsh_gnt,
  input  logic row_open,
  output logic ras_n,
  output logic cas_n,
  output logic bus_own,
  output logic rfsh_req,
  output logic close_req,
  output logic ready
);
  logic rst_core_n;
  logic tick, owed, dec;

  generate
    if (SYNC_STAGES < 2) begin : g_sync_one
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= 1'b1;
      end
      assign rst_core_n = s_q;
    end else begin : g_sync_chain
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= {s_q[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_core_n = s_q[SYNC_STAGES-1];
    end
  endgenerate

  rfsh_pace #(.INTERVAL_CYC(INTERVAL_CYC)) u_pace (
    .clk(clk), .rst_n(rst_core_n), .run(ready), .tick(tick)
  );

  rfsh_backlog #(.MAX_DEBT(MAX_DEBT)) u_backlog (
    .clk(clk), .rst_n(rst_core_n), .inc(tick), .dec(dec), .owed(owed)
  );

  rfsh_strobe_fsm #(
    .PAUSE_CYC(PAUSE_CYC), .INIT_CYCLES(INIT_CYCLES), .RP_CYC(RP_CYC),
    .CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC), .RAS_CYC(RAS_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_core_n), .owed(owed), .gnt(rfsh_gnt),
    .row_open(row_open), .ras_n(ras_n), .cas_n(cas_n), .bus_own(bus_own),
    .ready(ready), .dec(dec)
  );

  assign rfsh_req  = ready && (owed || bus_own);
  assign close_req = ready && owed && !bus_own && row_open;

  assert_strobe_owner_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!ras_n || !cas_n) |-> bus_own);

  assert_clean_start_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ready && $rose(bus_own)) |-> $past(rfsh_gnt && !row_open));

endmodule

// File: tb/tb_dram_rfsh_seq.sv
module tb_dram_rfsh_seq;
  localparam int PAUSE = 50, INIT = 8, IVL = 200, MAXD = 4;
  localparam int RP = 2, CSR = 1, CHR = 2, RAS = 4;
  localparam int NV = 6;
  localparam int VEC_WAIT [NV] = '{1, 2, 3, 6, 0, 1};
  localparam int VEC_OPEN [NV] = '{0, 3, 1, 5, 2, 0};
  localparam int VEC_EXP  [NV] = '{1, 2, 3, 4, 0, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rfsh_gnt = 1'b0;
  logic row_open = 1'b0;
  logic ras_n, cas_n, bus_own, rfsh_req, close_req, ready;

  always #2 clk = ~clk;

  dram_rfsh_seq #(
    .PAUSE_CYC(PAUSE), .INIT_CYCLES(INIT), .INTERVAL_CYC(IVL), .MAX_DEBT(MAXD),
    .RP_CYC(RP), .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_CYC(RAS), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .rfsh_gnt(rfsh_gnt), .row_open(row_open),
    .ras_n(ras_n), .cas_n(cas_n), .bus_own(bus_own), .rfsh_req(rfsh_req),
    .close_req(close_req), .ready(ready)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // strobe monitor, sampled on the falling edge
  bit prev_ras = 1, prev_cas = 1, prev_req = 0, seen_ready = 0, seen_req = 0, first_cas = 1;
  int cas_lo_run = 0, both_lo_run = 0, ras_lo_run = 0, hi_run = 0;
  int init_pulses = 0, pulse_cnt = 0, last_rise = 0, c0 = 0, req_cyc = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cas && !cas_n) begin
        if (first_cas) begin
          first_cas = 0;
          chk(hi_run == PAUSE + RP + 1, "R1 first CAS fall", hi_run, PAUSE + RP + 1);
        end else begin
          chk(hi_run >= RP, "R3 precharge before CAS", hi_run, RP);
        end
      end
      if (prev_ras && !ras_n) begin
        chk(!cas_n && cas_lo_run == CSR, "R3 CAS lead", cas_lo_run, CSR);
        chk(bus_own, "R7 owner at RAS fall", bus_own, 1);
        if (ready) begin
          pulse_cnt++;
          chk(rfsh_gnt, "R5 grant at RAS fall", rfsh_gnt, 1);
        end else init_pulses++;
      end
      if (!prev_ras && ras_n) begin
        chk(ras_lo_run == RAS, "R3 RAS width", ras_lo_run, RAS);
        last_rise = cyc;
      end
      if (!prev_cas && cas_n && !ras_n)
        chk(both_lo_run == CHR, "R3 CAS hold", both_lo_run, CHR);
      if (ready && !seen_ready) begin
        seen_ready = 1;
        c0 = cyc;
        chk(init_pulses == INIT, "R2 warm-up count", init_pulses, INIT);
        chk(cyc - last_rise == RP, "R2 ready delay", cyc - last_rise, RP);
      end
      if (seen_ready && !ready) chk(0, "R7 ready fell", 0, 1);
      if (seen_ready && rfsh_req && !seen_req) begin seen_req = 1; req_cyc = cyc; end
      if (seen_ready && prev_req && !rfsh_req) begin
        chk(cyc - last_rise == RP, "R8 request drop", cyc - last_rise, RP);
        chk(!bus_own, "R8 owner drop", bus_own, 0);
      end
      cas_lo_run  = cas_n ? 0 : cas_lo_run + 1;
      ras_lo_run  = ras_n ? 0 : ras_lo_run + 1;
      both_lo_run = (!cas_n && !ras_n) ? both_lo_run + 1 : 0;
      hi_run      = (cas_n && ras_n) ? hi_run + 1 : 0;
      prev_ras = ras_n;
      prev_cas = cas_n;
      prev_req = rfsh_req;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int k = 0;
    int exp_total = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ras_n && cas_n, "R1 strobes idle in reset", {ras_n, cas_n}, 3);
    chk(!ready && !rfsh_req && !bus_own, "R1 outputs low in reset",
        {ready, rfsh_req, bus_own}, 0);
    @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (PAUSE / 2) @(negedge clk);
    chk(ras_n && cas_n && !ready && !rfsh_req, "R1 quiet during pause",
        {ras_n, cas_n, ready, rfsh_req}, 12);
    while (!seen_ready) @(negedge clk);
    chk(!rfsh_req && !close_req, "R4 no request at ready", rfsh_req, 0);

    for (int v = 0; v < NV; v++) begin
      k += VEC_WAIT[v];
      while (cyc < c0 + k * IVL + 10) @(negedge clk);
      if (v == 0) chk(req_cyc - c0 == IVL, "R4 first request spacing", req_cyc - c0, IVL);
      chk(rfsh_req == (VEC_EXP[v] != 0), "R4 request while owed", rfsh_req, VEC_EXP[v] != 0);
      chk(pulse_cnt == exp_total, "R5 no refresh without grant", pulse_cnt, exp_total);
      row_open = (VEC_OPEN[v] != 0);
      rfsh_gnt = 1'b1;
      for (int o = 0; o < VEC_OPEN[v]; o++) begin
        @(negedge clk);
        chk(close_req == (VEC_EXP[v] != 0), "R5 close request", close_req, VEC_EXP[v] != 0);
        chk(!bus_own, "R5 wait for row close", bus_own, 0);
      end
      row_open = 1'b0;
      @(negedge clk);
      for (int w = 0; w < 300 && rfsh_req; w++) @(negedge clk);
      chk(!rfsh_req, "R8 request released", rfsh_req, 0);
      exp_total += VEC_EXP[v];
      chk(pulse_cnt == exp_total, "R6 refreshes per grant", pulse_cnt, exp_total);
      rfsh_gnt = 1'b0;
    end

    // ignored grant: nothing owed, row open, grant held
    rfsh_gnt = 1'b1;
    row_open = 1'b1;
    repeat (5) @(negedge clk);
    chk(!close_req && !bus_own, "R5 idle grant ignored", {close_req, bus_own}, 0);
    rfsh_gnt = 1'b0;
    row_open = 1'b0;
    @(negedge clk);
    chk(ready, "R7 ready held", ready, 1);
    done = 1;
    summary();
    $finish;
  end

endmodule